// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM from the state it is in just after power-on to a state where normal traffic can start. After reset it holds clock-enable low and waits until the clock has been stable for a set interval. It then raises clock-enable during a no-operation cycle. After that it issues the fixed bring-up series of commands: precharge of all banks, a write to the extended mode register that turns the DLL on, and a mode register write that resets the DLL. These are followed by a second precharge of all banks, a parameterised number of auto-refreshes and a final mode register write. Every cycle between commands carries a no-operation. Each command is followed by the minimum gap that its type requires.

The wait lengths come from elaboration parameters: the clock frequency in MHz and the stable-clock interval in microseconds, together with cycle counts for the precharge, mode-write and refresh gaps and for the DLL lock time. The burst length, burst type, CAS latency and output driver strength come in on configuration inputs. The block encodes them into the mode words. `init_done` rises when the memory may be used, and it stays high until the next reset. All pin outputs come from a register stage.

Top module: `ddr_init_seq`

## Requirements
- R1: For the first CLK_MHZ*STABLE_US+1 output cycles after reset release, `dram_cke` is low and the command pins show a no-operation (cs_n=0, ras_n=1, cas_n=1, we_n=1) with bank and address at zero.
- R2: `dram_cke` rises in output cycle CLK_MHZ*STABLE_US+1 with a no-operation on the command pins, and it stays high until reset. The first precharge follows in the next cycle.
- R3: The commands are issued in this order: precharge-all, extended mode write, mode write with DLL reset, precharge-all, REF_COUNT auto-refreshes, final mode write. No other command is issued.
- R4: The encodings on (cs_n,ras_n,cas_n,we_n) are: precharge 0,0,1,0 with address bit 10 high and all other address bits low; auto-refresh 0,0,0,1 with the address at zero; both mode writes 0,0,0,0. The bank address is 0 for the mode register and 1 (bank bit 0 high) for the extended register.
- R5: The next command comes T_RP cycles after a precharge, T_MRD cycles after either mode write and T_RFC cycles after an auto-refresh. Every cycle in between is a no-operation.
- R6: A mode write carries the burst-length code on address bits 2..0, the burst type on bit 3 (0 sequential, 1 interleave) and the CAS-latency code on bits 6..4. Bit 8 is high only in the DLL-reset write. Bit 7 and all bits above 8 are zero.
- R7: An extended mode write drives address bit 0 low (DLL on). It puts the driver code on bit 6 (high bit) and bit 1 (low bit), where 00 is full, 01 is weak and 10 is matched. The forbidden code 11 is sent as 00. All other address bits are zero.
- R8: `init_done` rises in the later of two cycles: the final mode write plus T_MRD, or the DLL-reset mode write plus DLL_LOCK. From then on it stays high with clock-enable high and no-operations on the pins.
- R9: A reset asserted in the middle of the sequence returns all outputs to the R1 state on the next edge. After release the whole sequence restarts from the stable-clock wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, also the memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_len | input | 3 | Burst-length code for mode bits 2..0 |
| cfg_burst_type | input | 1 | Burst type for mode bit 3 |
| cfg_cas_lat | input | 3 | CAS-latency code for mode bits 6..4 |
| cfg_drive | input | 2 | Output driver strength code |
| dram_cke | output | 1 | Clock enable to the memory |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_ba | output | BA_W | Bank address |
| dram_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Memory ready for normal operation |

## Verification
The bench compares every pin against a schedule it builds from the parameters, in every cycle from reset release until a few cycles after ready. A design with an off-by-one in any wait would show a command one cycle early or late. A design that clears the DLL-reset bit in the wrong write would show a wrong address word. One case is when the DLL lock time is longer than the command series. There a ready flag that only honours the last mode-write gap rises almost 170 cycles too soon. The forbidden driver code is applied to catch a design that passes it through. A reset in the middle of the series checks that the refresh count and lock progress are cleared, so that the restarted series is not shortened.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [3:0] {
        ST_STABLE,
        ST_CKE_NOP,
        ST_PRE1,
        ST_EMRS,
        ST_MRS_DLL,
        ST_PRE2,
        ST_AREF,
        ST_MRS_RUN,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_PRE_ALL,
        CMD_AREF,
        CMD_MRS,
        CMD_EMRS
    } dram_cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    // mode register field positions (decoded by the memory)
    localparam int MR_BL_LSB   = 0;
    localparam int MR_BT_BIT   = 3;
    localparam int MR_CL_LSB   = 4;
    localparam int MR_DLL_RST  = 8;
    // extended mode register field positions
    localparam int EMR_DLL_OFF = 0;
    localparam int EMR_DRV_LO  = 1;
    localparam int EMR_DRV_HI  = 6;
    // precharge-all select bit
    localparam int PRE_ALL_BIT = 10;

    localparam logic [1:0] DRV_FULL    = 2'b00;
    localparam logic [1:0] DRV_ILLEGAL = 2'b11;

    localparam cmd_pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic cmd_pins_t pins_of(input dram_cmd_e cmd);
        cmd_pins_t p;
        case (cmd)
            CMD_PRE_ALL: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_AREF:    p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_MRS,
            CMD_EMRS:    p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default:     p = PINS_NOP;
        endcase
        return p;
    endfunction

    function automatic logic [1:0] legal_drive(input logic [1:0] code);
        return (code == DRV_ILLEGAL) ? DRV_FULL : code;
    endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= W'(RST_VAL);
        end else if (load) begin
            count_q <= load_val;
        end else if (dec && (count_q != '0)) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign zero = (count_q == '0);
endmodule

// File: rtl/ddr_init_lock_ctr.sv
module ddr_init_lock_ctr #(
    parameter int LOCK = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic ok
);
    localparam int LOCK_C = (LOCK < 2) ? 2 : LOCK;
    localparam int CW     = $clog2(LOCK_C + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(1);
        end else if ((cnt_q != '0) && (cnt_q < CW'(LOCK_C))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // true in the cycle before the lock window has fully elapsed,
    // so a state change on this edge lands on the first legal cycle
    assign ok = (cnt_q >= CW'(LOCK_C - 1));
endmodule

// File: rtl/ddr_init_mode_words.sv
module ddr_init_mode_words
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [2:0]        burst_len,
    input  logic              burst_type,
    input  logic [2:0]        cas_lat,
    input  logic [1:0]        drive,
    input  logic              dll_rst,
    output logic [ADDR_W-1:0] mrs_word,
    output logic [ADDR_W-1:0] emrs_word
);
    logic [1:0] drv_ok;

    always_comb begin
        drv_ok = legal_drive(drive);

        mrs_word = '0;
        mrs_word[MR_BL_LSB +: 3] = burst_len;
        mrs_word[MR_BT_BIT]      = burst_type;
        mrs_word[MR_CL_LSB +: 3] = cas_lat;
        mrs_word[MR_DLL_RST]     = dll_rst;

        emrs_word = '0;
        emrs_word[EMR_DLL_OFF] = 1'b0;
        emrs_word[EMR_DRV_LO]  = drv_ok[0];
        emrs_word[EMR_DRV_HI]  = drv_ok[1];
    end
endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  dram_cmd_e         cmd,
    input  logic [ADDR_W-1:0] mrs_word,
    input  logic [ADDR_W-1:0] emrs_word,
    output cmd_pins_t         pins,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        pins = pins_of(cmd);
        ba   = '0;
        addr = '0;
        case (cmd)
            CMD_PRE_ALL: addr[PRE_ALL_BIT] = 1'b1;
            CMD_MRS:     addr = mrs_word;
            CMD_EMRS: begin
                addr = emrs_word;
                ba   = BA_W'(1);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int CLK_MHZ   = 125,
    parameter int STABLE_US = 200,
    parameter int T_RP      = 3,
    parameter int T_MRD     = 2,
    parameter int T_RFC     = 12,
    parameter int DLL_LOCK  = 200,
    parameter int REF_COUNT = 2,
    parameter int ADDR_W    = 13,
    parameter int BA_W      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_type,
    input  logic [2:0]        cfg_cas_lat,
    input  logic [1:0]        cfg_drive,
    output logic              dram_cke,
    output logic              dram_cs_n,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [BA_W-1:0]   dram_ba,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              init_done
);
    localparam int STABLE_CYC = imax(CLK_MHZ * STABLE_US, 1);
    localparam int GAP_RP     = imax(T_RP, 2) - 2;
    localparam int GAP_MRD    = imax(T_MRD, 2) - 2;
    localparam int GAP_RFC    = imax(T_RFC, 2) - 2;
    localparam int GAP_MAX    = imax(imax(GAP_RP, GAP_MRD), GAP_RFC);
    localparam int TMR_W      = $clog2(imax(STABLE_CYC, GAP_MAX) + 1);
    localparam int REF_C      = imax(REF_COUNT, 1);
    localparam int REF_W      = $clog2(REF_C + 1);

    seq_state_e state_q, state_nxt;
    seq_state_e ret_q, ret_nxt;

    logic             tmr_load, tmr_dec, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic             lock_start, lock_ok;
    logic [REF_W-1:0] ref_q;
    logic             ref_inc;

    dram_cmd_e         cmd_c;
    logic              dll_rst_c, cke_c, done_c;
    logic [ADDR_W-1:0] mrs_word, emrs_word;
    cmd_pins_t         pins_c, pins_q;
    logic [BA_W-1:0]   ba_c, ba_q;
    logic [ADDR_W-1:0] addr_c, addr_q;
    logic              cke_q, done_q;

    ddr_init_timer #(.W(TMR_W), .RST_VAL(STABLE_CYC - 1)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .dec(tmr_dec), .zero(tmr_zero)
    );

    ddr_init_lock_ctr #(.LOCK(DLL_LOCK)) u_lock (
        .clk(clk), .rst(rst), .start(lock_start), .ok(lock_ok)
    );

    ddr_init_mode_words #(.ADDR_W(ADDR_W)) u_words (
        .burst_len(cfg_burst_len), .burst_type(cfg_burst_type),
        .cas_lat(cfg_cas_lat), .drive(cfg_drive), .dll_rst(dll_rst_c),
        .mrs_word(mrs_word), .emrs_word(emrs_word)
    );

    ddr_init_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
        .cmd(cmd_c), .mrs_word(mrs_word), .emrs_word(emrs_word),
        .pins(pins_c), .ba(ba_c), .addr(addr_c)
    );

    always_comb begin
        state_nxt  = state_q;
        ret_nxt    = ret_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        tmr_dec    = 1'b0;
        cmd_c      = CMD_NOP;
        dll_rst_c  = 1'b0;
        cke_c      = 1'b1;
        done_c     = 1'b0;
        lock_start = 1'b0;
        ref_inc    = 1'b0;
        case (state_q)
            ST_STABLE: begin
                cke_c   = 1'b0;
                tmr_dec = 1'b1;
                if (tmr_zero) state_nxt = ST_CKE_NOP;
            end
            ST_CKE_NOP: state_nxt = ST_PRE1;
            ST_PRE1: begin
                cmd_c     = CMD_PRE_ALL;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(GAP_RP);
                ret_nxt   = ST_EMRS;
                state_nxt = ST_WAIT;
            end
            ST_EMRS: begin
                cmd_c     = CMD_EMRS;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(GAP_MRD);
                ret_nxt   = ST_MRS_DLL;
                state_nxt = ST_WAIT;
            end
            ST_MRS_DLL: begin
                cmd_c      = CMD_MRS;
                dll_rst_c  = 1'b1;
                lock_start = 1'b1;
                tmr_load   = 1'b1;
                tmr_val    = TMR_W'(GAP_MRD);
                ret_nxt    = ST_PRE2;
                state_nxt  = ST_WAIT;
            end
            ST_PRE2: begin
                cmd_c     = CMD_PRE_ALL;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(GAP_RP);
                ret_nxt   = ST_AREF;
                state_nxt = ST_WAIT;
            end
            ST_AREF: begin
                cmd_c     = CMD_AREF;
                ref_inc   = 1'b1;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(GAP_RFC);
                ret_nxt   = (ref_q == REF_W'(REF_C - 1)) ? ST_MRS_RUN : ST_AREF;
                state_nxt = ST_WAIT;
            end
            ST_MRS_RUN: begin
                cmd_c     = CMD_MRS;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(GAP_MRD);
                ret_nxt   = ST_DONE;
                state_nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (!tmr_zero) begin
                    tmr_dec = 1'b1;
                end else if ((ret_q != ST_DONE) || lock_ok) begin
                    state_nxt = ret_q;
                end
            end
            ST_DONE: done_c = 1'b1;
            default: state_nxt = ST_STABLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_STABLE;
            ret_q   <= ST_DONE;
            ref_q   <= '0;
        end else begin
            state_q <= state_nxt;
            ret_q   <= ret_nxt;
            if (ref_inc) ref_q <= ref_q + 1'b1;
        end
    end

    // registered pin stage: every output leaves a flop
    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q  <= 1'b0;
            pins_q <= PINS_NOP;
            ba_q   <= '0;
            addr_q <= '0;
            done_q <= 1'b0;
        end else begin
            cke_q  <= cke_c;
            pins_q <= pins_c;
            ba_q   <= ba_c;
            addr_q <= addr_c;
            done_q <= done_c;
        end
    end

    assign dram_cke   = cke_q;
    assign dram_cs_n  = pins_q.cs_n;
    assign dram_ras_n = pins_q.ras_n;
    assign dram_cas_n = pins_q.cas_n;
    assign dram_we_n  = pins_q.we_n;
    assign dram_ba    = ba_q;
    assign dram_addr  = addr_q;
    assign init_done  = done_q;
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
    parameter int ADDR_W   = 13,
    parameter int BA_W     = 2,
    parameter int DLL_LOCK = 200
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              done
);
    localparam int SW = $clog2(DLL_LOCK + 1) + 1;

    logic is_nop, is_pre, is_ref, is_mode, is_dll_mrs;
    assign is_nop  = !cs_n &&  ras_n &&  cas_n &&  we_n;
    assign is_pre  = !cs_n && !ras_n &&  cas_n && !we_n;
    assign is_ref  = !cs_n && !ras_n && !cas_n &&  we_n;
    assign is_mode = !cs_n && !ras_n && !cas_n && !we_n;
    assign is_dll_mrs = is_mode && (ba == '0) && addr[8];

    logic [SW-1:0] since_dll_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_dll_q <= '0;
        end else if (is_dll_mrs) begin
            since_dll_q <= SW'(1);
        end else if ((since_dll_q != '0) && (since_dll_q < SW'(DLL_LOCK))) begin
            since_dll_q <= since_dll_q + 1'b1;
        end
    end

    p_idle_while_cke_low_r1: assert property (@(posedge clk) disable iff (rst)
        !cke |-> is_nop);
    p_cke_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);
    p_legal_cmds_r3: assert property (@(posedge clk) disable iff (rst)
        is_nop || is_pre || is_ref || is_mode);
    p_pre_all_bit_r4: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> addr[10]);
    p_gap_after_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        !is_nop |=> is_nop);
    p_mrs_clean_r6: assert property (@(posedge clk) disable iff (rst)
        (is_mode && ba == '0) |-> (!addr[7] && (addr >> 9) == '0));
    p_emrs_clean_r7: assert property (@(posedge clk) disable iff (rst)
        (is_mode && ba == BA_W'(1)) |-> (!addr[0] && !(addr[6] && addr[1])
            && addr[5:2] == 4'b0 && (addr >> 7) == '0));
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (is_nop && cke));
    p_lock_window_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (since_dll_q >= SW'(DLL_LOCK)));
    p_reset_clears_r9: assert property (@(posedge clk)
        rst |=> (!cke && !done && is_nop));
endmodule

bind ddr_init_seq ddr_init_seq_chk #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .DLL_LOCK(DLL_LOCK)
) u_chk (
    .clk(clk), .rst(rst), .cke(dram_cke), .cs_n(dram_cs_n),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
    .ba(dram_ba), .addr(dram_addr), .done(init_done)
);

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;
    localparam int CLK_MHZ   = 125;
    localparam int STABLE_US = 2;
    localparam int T_RP      = 3;
    localparam int T_MRD     = 2;
    localparam int T_RFC     = 12;
    localparam int DLL_LOCK  = 200;
    localparam int REF_COUNT = 2;
    localparam int ADDR_W    = 13;
    localparam int BA_W      = 2;
    localparam int S         = CLK_MHZ * STABLE_US;

    localparam int K_PRE = 1, K_EMRS = 2, K_MRSD = 3, K_REF = 4, K_MRSF = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] cfg_bl = 3'b010;
    logic       cfg_bt = 1'b0;
    logic [2:0] cfg_cl = 3'b011;
    logic [1:0] cfg_drv = 2'b00;
    logic cke, cs_n, ras_n, cas_n, we_n, done;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    int exp_pos [0:15];
    int exp_kind[0:15];
    int exp_cnt;
    int exp_done_at;

    always #4 clk = ~clk;   // 125 MHz

    ddr_init_seq #(
        .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .T_RP(T_RP), .T_MRD(T_MRD),
        .T_RFC(T_RFC), .DLL_LOCK(DLL_LOCK), .REF_COUNT(REF_COUNT),
        .ADDR_W(ADDR_W), .BA_W(BA_W)
    ) u_dut (
        .clk(clk), .rst(rst), .cfg_burst_len(cfg_bl), .cfg_burst_type(cfg_bt),
        .cfg_cas_lat(cfg_cl), .cfg_drive(cfg_drv), .dram_cke(cke),
        .dram_cs_n(cs_n), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
        .dram_ba(ba), .dram_addr(addr), .init_done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected < 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // schedule from R2, R3 and R5; ready cycle from R8
    task automatic build_schedule();
        int p;
        int dpos;
        int fin;
        exp_cnt = 0;
        p = S + 2;
        exp_pos[exp_cnt] = p; exp_kind[exp_cnt] = K_PRE;  exp_cnt++; p += T_RP;
        exp_pos[exp_cnt] = p; exp_kind[exp_cnt] = K_EMRS; exp_cnt++; p += T_MRD;
        exp_pos[exp_cnt] = p; exp_kind[exp_cnt] = K_MRSD; exp_cnt++; dpos = p; p += T_MRD;
        exp_pos[exp_cnt] = p; exp_kind[exp_cnt] = K_PRE;  exp_cnt++; p += T_RP;
        for (int i = 0; i < REF_COUNT; i++) begin
            exp_pos[exp_cnt] = p; exp_kind[exp_cnt] = K_REF; exp_cnt++; p += T_RFC;
        end
        exp_pos[exp_cnt] = p; exp_kind[exp_cnt] = K_MRSF; exp_cnt++;
        fin = p + T_MRD;
        exp_done_at = (fin > dpos + DLL_LOCK) ? fin : dpos + DLL_LOCK;
    endtask

    function automatic logic [ADDR_W-1:0] mrs_exp(input logic dll);
        logic [ADDR_W-1:0] w = '0;
        w[2:0] = cfg_bl;
        w[3]   = cfg_bt;
        w[6:4] = cfg_cl;
        w[8]   = dll;
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] emrs_exp();
        logic [ADDR_W-1:0] w = '0;
        logic [1:0] d = (cfg_drv == 2'b11) ? 2'b00 : cfg_drv;
        w[1] = d[0];
        w[6] = d[1];
        return w;
    endfunction

    task automatic check_cycle(int n);
        int kind = 0;
        logic [3:0] pins_e;
        logic [ADDR_W-1:0] addr_e = '0;
        logic [BA_W-1:0] ba_e = '0;
        string rq_addr;
        for (int i = 0; i < exp_cnt; i++) if (exp_pos[i] == n) kind = exp_kind[i];
        pins_e  = 4'b0111;
        rq_addr = "R1";
        case (kind)
            K_PRE:  begin pins_e = 4'b0010; addr_e[10] = 1'b1; rq_addr = "R4"; end
            K_REF:  begin pins_e = 4'b0001; rq_addr = "R4"; end
            K_EMRS: begin pins_e = 4'b0000; addr_e = emrs_exp(); ba_e = 1; rq_addr = "R7"; end
            K_MRSD: begin pins_e = 4'b0000; addr_e = mrs_exp(1'b1); rq_addr = "R6"; end
            K_MRSF: begin pins_e = 4'b0000; addr_e = mrs_exp(1'b0); rq_addr = "R6"; end
            default: ;
        endcase
        check((n <= S) ? "R1" : "R2", $sformatf("cke @%0d", n), 32'(cke), 32'(n >= S + 1));
        check((kind == 0) ? "R5" : "R3", $sformatf("cmd pins @%0d", n),
              32'({cs_n, ras_n, cas_n, we_n}), 32'(pins_e));
        check(rq_addr, $sformatf("addr @%0d", n), 32'(addr), 32'(addr_e));
        check(rq_addr, $sformatf("bank @%0d", n), 32'(ba), 32'(ba_e));
        check("R8", $sformatf("done @%0d", n), 32'(done), 32'(n >= exp_done_at));
    endtask

    // full trace from release to a few cycles past ready
    task automatic run_trace(logic [2:0] bl, logic bt, logic [2:0] cl, logic [1:0] drv);
        cfg_bl = bl; cfg_bt = bt; cfg_cl = cl; cfg_drv = drv;
        build_schedule();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        for (int n = 0; n <= exp_done_at + 4; n++) begin
            if (n > 0) @(negedge clk);
            check_cycle(n);
        end
    endtask

    task automatic test_reset_state();   // R1
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "cke in reset", 32'(cke), 32'd0);
        check("R1", "pins in reset", 32'({cs_n, ras_n, cas_n, we_n}), 32'h7);
        check("R1", "done in reset", 32'(done), 32'd0);
    endtask

    task automatic test_basic();         // BL4 sequential CL3 full drive
        run_trace(3'b010, 1'b0, 3'b011, 2'b00);
    endtask

    task automatic test_interleave_matched();  // BL8 interleave, matched drive
        run_trace(3'b011, 1'b1, 3'b011, 2'b10);
    endtask

    task automatic test_illegal_drive_r7();    // code 11 must go out as full
        run_trace(3'b001, 1'b0, 3'b010, 2'b11);
    endtask

    task automatic test_mid_reset_r9();
        cfg_drv = 2'b01;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (S + 9) @(negedge clk);     // past the DLL-reset write
        rst = 1'b1;
        @(negedge clk);
        check("R9", "cke after mid reset", 32'(cke), 32'd0);
        check("R9", "pins after mid reset", 32'({cs_n, ras_n, cas_n, we_n}), 32'h7);
        check("R9", "addr after mid reset", 32'(addr), 32'd0);
        check("R9", "done after mid reset", 32'(done), 32'd0);
        run_trace(3'b010, 1'b1, 3'b011, 2'b01);  // R9 restart is complete
    endtask

    initial begin
        test_reset_state();
        test_basic();
        test_interleave_matched();
        test_illegal_drive_r7();
        test_mid_reset_r9();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule